// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Builder

This block turns a request, given as a stream of scatter-gather segments, into a table of 8-byte descriptors that a bus-mastering disk controller walks during a DMA transfer. Each segment carries a 32-bit bus address and a 32-bit byte length. Segments arrive over a valid/ready handshake, and a last flag closes the request. The block cuts every segment into chunks so that no descriptor spans a 64 KB address window. It writes the descriptors in order, at consecutive indices, to a descriptor memory port. When the request ends, it pulses a done strobe together with the number of descriptors written.

A count of zero tells the caller to serve the request by programmed I/O. This happens for an empty request and for a request that would overflow the table. Some controllers read a 16-bit length of zero as zero bytes, so in the normal encoding a full 64 KB chunk is always written as two 32 KB descriptors. An alternate encoding serves a controller variant that works in 32-bit units. In that encoding the length sits in the upper half of the control word, and no end-of-table mark is written.

Top module: `prd_table_builder`

## Requirements
- R1: Each descriptor is written as one port write. `mem_addr_word` holds the chunk start address. In normal mode (`mode_alt`=0), `mem_ctrl_word[15:0]` holds the chunk byte count and bits [30:16] are zero.
- R2: A segment is cut into chunks. Each chunk is min(remaining length, 0x10000 − address[15:0]). After each chunk, the address advances and the remaining length shrinks by the chunk size, so no descriptor crosses a 64 KB boundary.
- R3: In normal mode, a chunk of exactly 0x10000 bytes becomes two descriptors, (addr, 0x8000) then (addr+0x8000, 0x8000). No normal-mode descriptor has a count field of zero.
- R4: In normal mode, bit 31 of the control word is set on the last descriptor of a request and on no other descriptor. Zero-length segments produce no descriptor, so the mark falls on the last real descriptor.
- R5: `done_o` is a one-cycle pulse after the segment flagged last has been consumed. `done_count` gives the descriptor count. A request whose segments are all zero-length reports 0.
- R6: A request needing more than CAP descriptors reports a count of 0. Its remaining segments, up to and including the one flagged last, are still accepted and discarded. A request needing exactly CAP descriptors succeeds.
- R7: In alternate mode (`mode_alt`=1), `mem_ctrl_word[31:16]` = ((count mod 65536)/4 − 1) mod 65536 and bits [15:0] are zero. A full 64 KB chunk is one descriptor with field 0xFFFF, and no end mark is set. Addresses and lengths are multiples of 4.
- R8: `seg_ready` goes low in the cycle after a non-empty segment is accepted and stays low until that segment has been cut into chunks. The descriptors of a request go to indices 0, 1, 2, … in order.
- R9: After reset, `seg_ready` is 1, `mem_we` is 0 and `done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_alt | input | 1 | Selects the alternate length encoding; held steady during a request |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Block accepts a segment |
| seg_addr | input | 32 | Segment bus address |
| seg_len | input | 32 | Segment byte length |
| seg_last | input | 1 | Segment closes the request |
| mem_we | output | 1 | Descriptor write strobe |
| mem_idx | output | clog2(CAP) | Descriptor index |
| mem_addr_word | output | 32 | Descriptor address word |
| mem_ctrl_word | output | 32 | Descriptor control word |
| done_o | output | 1 | Request finished |
| done_count | output | clog2(CAP+1) | Descriptors written, 0 for fallback |

## Verification
Faults in the chunk arithmetic appear at the memory port on the first descriptor of the affected segment. They show up as a wrong count field or a wrong next start address, one cycle per descriptor. A miscounted table fill or a wrong end-mark position only becomes visible when `done_o` pulses: the count is wrong, or bit 31 sits on the wrong entry. The sweep therefore compares every written word and every final count against an arithmetic model, at each start offset and length class in both encodings.

// File: rtl/prd_pkg.sv
package prd_pkg;

    // Size of the address window that a descriptor must not cross, and half of it.
    localparam logic [16:0] WIN_BYTES  = 17'h10000;
    localparam logic [16:0] HALF_BYTES = 17'h08000;

    typedef enum logic [1:0] {
        ST_TAKE,
        ST_SPLIT,
        ST_FLUSH,
        ST_DRAIN
    } bld_state_e;

    // One descriptor waiting to be written.
    typedef struct packed {
        logic [31:0] addr;
        logic [15:0] len16;
    } pend_entry_t;

    // Length field for the word-unit encoding: quarter of the byte count, minus one.
    function automatic logic [15:0] alt_field(input logic [15:0] len16);
        return (len16 >> 2) - 16'd1;
    endfunction

endpackage

// File: rtl/prd_chunker.sv
module prd_chunker
    import prd_pkg::*;
(
    input  logic [15:0] addr_lo,
    input  logic [31:0] rem,
    input  logic        alt,
    output logic [16:0] len
);
    logic [16:0] room;

    always_comb begin
        room = WIN_BYTES - {1'b0, addr_lo};
        if (rem < {15'h0, room})
            len = rem[16:0];
        else
            len = room;
        // A full window cannot be encoded in 16 bits in normal mode: take half.
        if (!alt && len == WIN_BYTES)
            len = HALF_BYTES;
    end
endmodule

// File: rtl/prd_ctrl_fmt.sv
module prd_ctrl_fmt
    import prd_pkg::*;
(
    input  logic [15:0] len16,
    input  logic        alt,
    input  logic        end_mark,
    output logic [31:0] ctrl
);
    always_comb begin
        if (alt)
            ctrl = {alt_field(len16), 16'h0000};
        else
            ctrl = {end_mark, 15'h0000, len16};
    end
endmodule

// File: rtl/prd_table_builder.sv
module prd_table_builder
    import prd_pkg::*;
#(
    parameter  int CAP   = 256,
    localparam int IDX_W = (CAP > 1) ? $clog2(CAP) : 1,
    localparam int CNT_W = $clog2(CAP + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_alt,
    input  logic             seg_valid,
    output logic             seg_ready,
    input  logic [31:0]      seg_addr,
    input  logic [31:0]      seg_len,
    input  logic             seg_last,
    output logic             mem_we,
    output logic [IDX_W-1:0] mem_idx,
    output logic [31:0]      mem_addr_word,
    output logic [31:0]      mem_ctrl_word,
    output logic             done_o,
    output logic [CNT_W-1:0] done_count
);
    localparam logic [CNT_W-1:0] CAP_C = CNT_W'(CAP);

    bld_state_e  state;
    logic [31:0] cur_addr;
    logic [31:0] rem;
    logic        cur_last;
    pend_entry_t pend;
    logic        pend_v;
    logic [CNT_W-1:0] count;

    logic [16:0]      chunk_len;
    logic [31:0]      rem_next;
    logic             full;
    logic [CNT_W-1:0] cnt_m1;

    prd_chunker chunk_i (
        .addr_lo (cur_addr[15:0]),
        .rem     (rem),
        .alt     (mode_alt),
        .len     (chunk_len)
    );

    prd_ctrl_fmt fmt_i (
        .len16    (pend.len16),
        .alt      (mode_alt),
        .end_mark (state == ST_FLUSH),
        .ctrl     (mem_ctrl_word)
    );

    assign rem_next      = rem - {15'h0, chunk_len};
    assign full          = (count == CAP_C);
    assign cnt_m1        = count - 1'b1;
    assign seg_ready     = (state == ST_TAKE) || (state == ST_DRAIN);
    assign mem_we        = pend_v && ((state == ST_FLUSH) || (state == ST_SPLIT && !full));
    assign mem_idx       = cnt_m1[IDX_W-1:0];
    assign mem_addr_word = pend.addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_TAKE;
            cur_addr   <= '0;
            rem        <= '0;
            cur_last   <= 1'b0;
            pend       <= '0;
            pend_v     <= 1'b0;
            count      <= '0;
            done_o     <= 1'b0;
            done_count <= '0;
        end else begin
            done_o <= 1'b0;
            case (state)
                ST_TAKE: begin
                    if (seg_valid) begin
                        cur_addr <= seg_addr;
                        rem      <= seg_len;
                        cur_last <= seg_last;
                        if (seg_len != 32'd0)
                            state <= ST_SPLIT;
                        else if (seg_last)
                            state <= ST_FLUSH;
                    end
                end
                ST_SPLIT: begin
                    if (full) begin
                        pend_v <= 1'b0;
                        count  <= '0;
                        if (cur_last) begin
                            done_o     <= 1'b1;
                            done_count <= '0;
                            state      <= ST_TAKE;
                        end else begin
                            state <= ST_DRAIN;
                        end
                    end else begin
                        pend     <= '{addr: cur_addr, len16: chunk_len[15:0]};
                        pend_v   <= 1'b1;
                        count    <= count + 1'b1;
                        cur_addr <= cur_addr + {15'h0, chunk_len};
                        rem      <= rem_next;
                        if (rem_next == 32'd0)
                            state <= cur_last ? ST_FLUSH : ST_TAKE;
                    end
                end
                ST_FLUSH: begin
                    done_o     <= 1'b1;
                    done_count <= count;
                    count      <= '0;
                    pend_v     <= 1'b0;
                    state      <= ST_TAKE;
                end
                ST_DRAIN: begin
                    if (seg_valid && seg_last) begin
                        done_o     <= 1'b1;
                        done_count <= '0;
                        state      <= ST_TAKE;
                    end
                end
                default: state <= ST_TAKE;
            endcase
        end
    end

    // R2
    no_cross_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SPLIT && !full) |->
            (chunk_len != 17'd0 && ({1'b0, cur_addr[15:0]} + {1'b0, chunk_len}) <= 18'h10000));

    // R3
    no_zero_len_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !mode_alt) |-> (mem_ctrl_word[15:0] != 16'd0));

    // R4
    end_then_done_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !mode_alt && mem_ctrl_word[31]) |=> (done_o && done_count != '0));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6
    cap_bound_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (done_count <= CAP_C));

    // R8
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TAKE && seg_valid && seg_len != 32'd0) |=> !seg_ready);

endmodule

// File: tb/prd_table_builder_tb_top.sv
module prd_table_builder_tb_top;
    localparam int CAP   = 8;
    localparam int IDX_W = $clog2(CAP);
    localparam int CNT_W = $clog2(CAP + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_alt = 1'b0;
    logic seg_valid = 1'b0;
    logic seg_ready;
    logic [31:0] seg_addr = '0;
    logic [31:0] seg_len = '0;
    logic seg_last = 1'b0;
    logic mem_we;
    logic [IDX_W-1:0] mem_idx;
    logic [31:0] mem_addr_word, mem_ctrl_word;
    logic done_o;
    logic [CNT_W-1:0] done_count;

    always #5 clk = ~clk;

    prd_table_builder #(.CAP(CAP)) dut_i (
        .clk(clk), .rst(rst), .mode_alt(mode_alt),
        .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
        .seg_len(seg_len), .seg_last(seg_last),
        .mem_we(mem_we), .mem_idx(mem_idx), .mem_addr_word(mem_addr_word),
        .mem_ctrl_word(mem_ctrl_word), .done_o(done_o), .done_count(done_count)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Captured port activity
    logic [31:0] cap_a [64];
    logic [31:0] cap_c [64];
    int          cap_i [64];
    int          cap_n;
    bit          done_seen;
    int          done_val;

    // Request description and expected table
    logic [31:0] sg_a [16];
    logic [31:0] sg_l [16];
    int          sg_n;
    logic [31:0] ex_a [64];
    logic [31:0] ex_c [64];
    int          ex_n;
    bit          ex_ovf;

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we && cap_n < 64) begin
                cap_a[cap_n] = mem_addr_word;
                cap_c[cap_n] = mem_ctrl_word;
                cap_i[cap_n] = int'(mem_idx);
                cap_n = cap_n + 1;
            end
            if (done_o) begin
                done_seen = 1'b1;
                done_val  = int'(done_count);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic build_exp(input bit alt);
        ex_n = 0;
        ex_ovf = 1'b0;
        for (int s = 0; s < sg_n; s++) begin
            longint a = longint'(sg_a[s]);
            longint r = longint'(sg_l[s]);
            while (r != 0 && ex_n < 40) begin
                longint room = 65536 - (a & 'hFFFF);
                longint c = (r < room) ? r : room;
                longint c16;
                if (!alt && c == 65536) c = 32768;
                c16 = c & 'hFFFF;
                ex_a[ex_n] = a[31:0];
                if (alt) ex_c[ex_n] = {16'(((c16 >> 2) - 1) & 'hFFFF), 16'h0000};
                else     ex_c[ex_n] = {16'h0000, 16'(c16)};
                ex_n++;
                a = a + c;
                r = r - c;
            end
        end
        if (ex_n > CAP) ex_ovf = 1'b1;
        if (!alt && ex_n > 0 && !ex_ovf) ex_c[ex_n-1][31] = 1'b1;
    endtask

    task automatic send_all();
        for (int s = 0; s < sg_n; s++) begin
            @(negedge clk);
            seg_valid = 1'b1;
            seg_addr  = sg_a[s];
            seg_len   = sg_l[s];
            seg_last  = (s == sg_n - 1);
            while (!seg_ready) @(negedge clk);
            @(negedge clk);
            seg_valid = 1'b0;
            seg_last  = 1'b0;
        end
    endtask

    task automatic run_req(input bit alt, input string tag);
        int w;
        @(negedge clk);
        cap_n = 0;
        done_seen = 1'b0;
        mode_alt = alt;
        build_exp(alt);
        send_all();
        w = 0;
        while (!done_seen && w < 2000) begin
            @(negedge clk);
            w++;
        end
        // R5 / R6: reported count
        chk(done_seen && done_val == (ex_ovf ? 0 : ex_n), {tag, " count"},
            done_val, ex_ovf ? 0 : ex_n);
        if (!ex_ovf) begin
            chk(cap_n == ex_n, {tag, " writes"}, cap_n, ex_n);
            for (int i = 0; i < ex_n && i < cap_n; i++) begin
                // R8: consecutive indices
                chk(cap_i[i] == i, {tag, " R8 index"}, cap_i[i], i);
                chk(cap_a[i] == ex_a[i], {tag, " addr"}, cap_a[i], ex_a[i]);
                chk(cap_c[i] == ex_c[i], {tag, " ctrl"}, cap_c[i], ex_c[i]);
            end
        end else begin
            for (int i = 0; i < cap_n; i++)
                chk(cap_c[i][31] == 1'b0, {tag, " no end mark on abort"}, cap_c[i], 0);
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            cap_a[i] = '0; cap_c[i] = '0; cap_i[i] = 0;
        end
        cap_n = 0;
        done_seen = 1'b0;
        done_val = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        chk(seg_ready == 1'b1, "R9 ready", seg_ready, 1);
        chk(mem_we == 1'b0, "R9 we", mem_we, 0);
        chk(done_o == 1'b0, "R9 done", done_o, 0);

        // R1: small segment
        sg_n = 1; sg_a[0] = 32'h1000_0100; sg_l[0] = 32'h200;
        run_req(1'b0, "R1 single");
        // R2: crosses a 64 KB boundary
        sg_a[0] = 32'h0001_FF00; sg_l[0] = 32'h300;
        run_req(1'b0, "R2 cross");
        // R3: full aligned 64 KB
        sg_a[0] = 32'h0003_0000; sg_l[0] = 32'h10000;
        run_req(1'b0, "R3 full");
        // R4: zero-length last segment
        sg_n = 2; sg_a[0] = 32'h5000; sg_l[0] = 32'h10; sg_a[1] = 32'h6000; sg_l[1] = 32'h0;
        run_req(1'b0, "R4 zero tail");
        // R5: empty request
        sg_n = 1; sg_a[0] = 32'h7000; sg_l[0] = 32'h0;
        run_req(1'b0, "R5 empty");
        // R6: overflow inside the last segment
        sg_n = 1; sg_a[0] = 32'h0010_0000; sg_l[0] = 32'h80000;
        run_req(1'b0, "R6 overflow");
        // R6: overflow, then further segments drained
        sg_n = 3; sg_a[0] = 32'h0010_0000; sg_l[0] = 32'h80000;
        sg_a[1] = 32'h200; sg_l[1] = 32'h40; sg_a[2] = 32'h300; sg_l[2] = 32'h4;
        run_req(1'b0, "R6 drain");
        // R6: exactly CAP descriptors
        sg_n = 1; sg_a[0] = 32'h0010_0000; sg_l[0] = 32'h40000;
        run_req(1'b0, "R6 exact cap");
        // R7: alternate encoding
        sg_a[0] = 32'h0004_0000; sg_l[0] = 32'h10000;
        run_req(1'b1, "R7 alt full");
        sg_a[0] = 32'h0001_FFF0; sg_l[0] = 32'h40;
        run_req(1'b1, "R7 alt cross");
        // R4: several segments, mark on last only
        sg_n = 3; sg_a[0] = 32'h0000_FFF0; sg_l[0] = 32'h20;
        sg_a[1] = 32'h0008_0000; sg_l[1] = 32'h0; sg_a[2] = 32'h0009_8000; sg_l[2] = 32'h8000;
        run_req(1'b0, "R4 multi");

        // R2 R3 R7: sweep start offsets and length classes in both encodings
        for (int m = 0; m < 2; m++) begin
            for (int oi = 0; oi < 4; oi++) begin
                for (int li = 0; li < 6; li++) begin
                    logic [31:0] offs [4];
                    logic [31:0] lens [6];
                    offs = '{32'h0, 32'h4, 32'h7FFC, 32'hFFF8};
                    lens = '{32'h4, 32'h100, 32'h8000, 32'hFFFC, 32'h10000, 32'h18004};
                    sg_n = 1;
                    sg_a[0] = 32'h0002_0000 + offs[oi];
                    sg_l[0] = lens[li];
                    run_req(m[0], m[0] ? "R7 sweep" : "R2 sweep");
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule